// File: doc/BRIEF.md
# Gate driver protection and fault-clear controller

This clocked controller sits between a PWM source and a single low-side gate driver stage. When the block is enabled and no fault is present, it passes the PWM input to the gate output in phase. It also watches two supervisory comparator results that have already been digitized. The first is an overcurrent comparator. The second is a pair of supply comparators: one reports that the supply is below the falling threshold, the other that it is above the rising threshold. The block qualifies each of these over time and latches a fault.

A latched fault turns the gate output off and asks an open-drain line to be pulled low. The line is released only when two things are both true: the fault condition has gone, and a programmable clear interval, counted in clock cycles, has run out since the last qualified fault. The same shared line is read back as a non-latched enable. Pulling it low from outside switches the gate off, and when it is released the gate follows PWM again. Every input passes through a two-flop synchronizer before use. All delays are parameters in clock cycles.

Top module: `gdrv_prot_ctrl`

## Requirements
- R1: While a fault is latched (flt_pull_low = 1), gate_out is 0 whatever pwm_in and en_sense are. The two outputs change on the same clock edge.
- R2: An overcurrent assertion is qualified only when oc_cmp has been high for more than BLANK_CYC consecutive cycles. A pulse of N cycles, applied just after edge E0, sets flt_pull_low at edge E0+3+BLANK_CYC if N > BLANK_CYC. A pulse with N <= BLANK_CYC has no effect on either output.
- R3: Undervoltage is qualified only when uv_below_fall has been high for more than UVF_CYC consecutive cycles. Shorter dips leave both outputs unchanged. A qualifying dip starting after edge E0 sets flt_pull_low at edge E0+3+UVF_CYC.
- R4: Undervoltage has hysteresis. Once entered, it persists while uv_below_fall is 0 and uv_above_rise is 0. It clears only when uv_above_rise is 1, and flt_pull_low may then fall at the earliest 4 edges after uv_above_rise rises.
- R5: Each qualified fault loads a clear timer with CLR_CYC. flt_pull_low falls CLR_CYC+1 edges after the last fault load, or 4 edges after the supply recovers, whichever is later. A persistent overcurrent keeps reloading the timer: with oc_cmp held N cycles from E0, the release edge is E0+N+3+CLR_CYC.
- R6: A new qualified fault while the clear timer is running reloads the timer, so the release is counted from the newest fault.
- R7: After reset, flt_pull_low = 1 and gate_out = 0. They stay that way while uv_above_rise is 0, however long that lasts, and the line is released 4 edges after uv_above_rise rises once the clear interval has passed.
- R8: en_sense = 0 turns gate_out off 3 edges after the change, and en_sense = 1 restores it 3 edges after the change. This enable is not latched and does not set flt_pull_low.
- R9: With no fault and en_sense = 1, gate_out equals the pwm_in value applied 3 edges earlier (two synchronizer stages plus the output register).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| pwm_in | input | 1 | PWM command, active high |
| oc_cmp | input | 1 | Overcurrent comparator result, high when tripped |
| uv_below_fall | input | 1 | Supply is below the falling undervoltage threshold |
| uv_above_rise | input | 1 | Supply is above the rising undervoltage threshold |
| en_sense | input | 1 | Sampled level of the shared enable/fault line |
| gate_out | output | 1 | Registered gate command, active high |
| flt_pull_low | output | 1 | 1 drives the shared line low; 0 releases it to the pull-up |

## Verification
The bench builds the block with BLANK_CYC = 3, UVF_CYC = 4 and CLR_CYC = 10. With values this small, every overcurrent pulse length from one cycle to three cycles beyond the blanking limit can be swept, and so can every dip length from one cycle to past the end of the clear timer. Each of these cases has its release edge worked out arithmetically and checked cycle by cycle. The short timer also makes the remaining cases cheap to reach: both orderings of supply recovery against timer expiry, a reload from a second fault, the hold between the two thresholds, and the power-up wait.

// File: rtl/gdrv_pkg.sv
package gdrv_pkg;
  // counter width able to hold values 0..n
  function automatic int cw(input int n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/gdrv_sync.sv
module gdrv_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1;
  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= '0;
      q  <= '0;
    end else begin
      s1 <= d;
      q  <= s1;
    end
  end
endmodule

// File: rtl/gdrv_qual.sv
module gdrv_qual #(
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic trip
);
  localparam int CW = gdrv_pkg::cw(LIMIT);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);
  logic [CW-1:0] cnt;

  assign trip = lvl && (cnt == LIM);

  always_ff @(posedge clk) begin
    if (rst)            cnt <= '0;
    else if (!lvl)      cnt <= '0;
    else if (cnt != LIM) cnt <= cnt + CW'(1);
  end
endmodule

// File: rtl/gdrv_fault.sv
module gdrv_fault #(
  parameter int CLR_CYC = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic oc_trip,
  input  logic uv_trip,
  input  logic uv_ok,
  output logic uv_low,
  output logic flt_q,
  output logic flt_d,
  output logic tmr_zero
);
  localparam int TW = gdrv_pkg::cw(CLR_CYC);
  logic [TW-1:0] tmr;
  logic          load;

  assign load     = oc_trip | uv_trip;
  assign tmr_zero = (tmr == '0);

  always_comb begin
    if (load)                      flt_d = 1'b1;
    else if (tmr_zero && !uv_low)  flt_d = 1'b0;
    else                           flt_d = flt_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      uv_low <= 1'b1;
      tmr    <= TW'(CLR_CYC);
      flt_q  <= 1'b1;
    end else begin
      if (uv_trip)    uv_low <= 1'b1;
      else if (uv_ok) uv_low <= 1'b0;
      if (load)           tmr <= TW'(CLR_CYC);
      else if (!tmr_zero) tmr <= tmr - TW'(1);
      flt_q <= flt_d;
    end
  end
endmodule

// File: rtl/gdrv_prot_ctrl.sv
module gdrv_prot_ctrl #(
  parameter int BLANK_CYC = 45,
  parameter int UVF_CYC   = 500,
  parameter int CLR_CYC   = 27000
) (
  input  logic clk,
  input  logic rst,
  input  logic pwm_in,
  input  logic oc_cmp,
  input  logic uv_below_fall,
  input  logic uv_above_rise,
  input  logic en_sense,
  output logic gate_out,
  output logic flt_pull_low
);
  localparam int NSYNC = 5;
  logic [NSYNC-1:0] raw, synced;
  logic pwm_s, oc_s, uvb_s, uva_s, en_s;
  logic oc_trip, uv_trip, uv_low, flt_d, tmr_zero;

  assign raw = {pwm_in, oc_cmp, uv_below_fall, uv_above_rise, en_sense};
  assign {pwm_s, oc_s, uvb_s, uva_s, en_s} = synced;

  gdrv_sync #(.W(NSYNC)) u_sync (
    .clk(clk), .rst(rst), .d(raw), .q(synced)
  );

  gdrv_qual #(.LIMIT(BLANK_CYC)) u_oc_qual (
    .clk(clk), .rst(rst), .lvl(oc_s), .trip(oc_trip)
  );

  gdrv_qual #(.LIMIT(UVF_CYC)) u_uv_qual (
    .clk(clk), .rst(rst), .lvl(uvb_s & ~uv_low), .trip(uv_trip)
  );

  gdrv_fault #(.CLR_CYC(CLR_CYC)) u_fault (
    .clk(clk), .rst(rst), .oc_trip(oc_trip), .uv_trip(uv_trip),
    .uv_ok(uva_s), .uv_low(uv_low), .flt_q(flt_pull_low),
    .flt_d(flt_d), .tmr_zero(tmr_zero)
  );

  always_ff @(posedge clk) begin
    if (rst) gate_out <= 1'b0;
    else     gate_out <= pwm_s & en_s & ~flt_d;
  end
endmodule

// File: rtl/gdrv_prot_chk.sv
module gdrv_prot_chk (
  input logic clk,
  input logic rst,
  input logic flt,
  input logic gate,
  input logic en_s,
  input logic oc_s,
  input logic oc_trip,
  input logic uv_low,
  input logic uva_s,
  input logic tmr_zero
);
  AST_GATE_OFF_IN_FAULT: assert property (@(posedge clk) disable iff (rst) flt |-> !gate); // R1
  AST_OC_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst) oc_trip |-> $past(oc_s)); // R2
  AST_UV_HYST_HOLD: assert property (@(posedge clk) disable iff (rst) (uv_low && !uva_s) |=> uv_low); // R4
  AST_FLT_HOLD_TMR: assert property (@(posedge clk) disable iff (rst) (flt && !tmr_zero) |=> flt); // R5
  AST_FLT_HOLD_UV: assert property (@(posedge clk) disable iff (rst) (flt && uv_low) |=> flt); // R7
  AST_EN_OFF: assert property (@(posedge clk) disable iff (rst) !en_s |=> !gate); // R8
endmodule

bind gdrv_prot_ctrl gdrv_prot_chk u_chk (
  .clk(clk), .rst(rst), .flt(flt_pull_low), .gate(gate_out), .en_s(en_s),
  .oc_s(oc_s), .oc_trip(oc_trip), .uv_low(uv_low), .uva_s(uva_s),
  .tmr_zero(tmr_zero)
);

// File: tb/gdrv_prot_ctrl_bench.sv
`timescale 1ns/1ps
module gdrv_prot_ctrl_bench;
  localparam int BLANK = 3;
  localparam int UVF   = 4;
  localparam int CLR   = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pwm_in = 1'b1, oc_cmp = 1'b0, uvb = 1'b0, uva = 1'b0, en = 1'b1;
  logic gate_out, flt_pull_low;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gdrv_prot_ctrl #(.BLANK_CYC(BLANK), .UVF_CYC(UVF), .CLR_CYC(CLR)) u_gdrv_prot_ctrl (
    .clk(clk), .rst(rst), .pwm_in(pwm_in), .oc_cmp(oc_cmp),
    .uv_below_fall(uvb), .uv_above_rise(uva), .en_sense(en),
    .gate_out(gate_out), .flt_pull_low(flt_pull_low)
  );

  task automatic chk(input logic act, input logic exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    #(4 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic hist [0:63];
    int rel;
    bit trip;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R7 reset state
    chk(flt_pull_low, 1'b1, "R7 reset flt");
    chk(gate_out, 1'b0, "R7 reset gate");
    for (int k = 1; k <= 2 * CLR; k++) begin
      tick();
      chk(flt_pull_low, 1'b1, "R7 held while below rise");
      chk(gate_out, 1'b0, "R7 gate off at power-up");
    end
    uva = 1'b1;
    for (int k = 1; k <= 6; k++) begin
      tick();
      chk(flt_pull_low, (k < 4), "R7 release after rise");
      chk(gate_out, !(k < 4), "R1 gate vs fault at power-up");
    end
    idle(4);

    // R2/R5 overcurrent pulse sweep
    for (int n = 1; n <= BLANK + 3; n++) begin
      trip = (n > BLANK);
      oc_cmp = 1'b1;
      for (int k = 1; k <= n + CLR + 8; k++) begin
        tick();
        if (k == n) oc_cmp = 1'b0;
        chk(flt_pull_low, trip && (k >= 3 + BLANK) && (k < n + 3 + CLR), "R2 R5 oc sweep flt");
        chk(gate_out, !(trip && (k >= 3 + BLANK) && (k < n + 3 + CLR)), "R1 oc sweep gate");
      end
      idle(3);
    end

    // R3/R5 undervoltage dip sweep, recovery at end of dip
    for (int n = 1; n <= UVF + CLR + 6; n++) begin
      trip = (n > UVF);
      rel = (3 + UVF + CLR + 1 > n + 4) ? (3 + UVF + CLR + 1) : (n + 4);
      uvb = 1'b1;
      uva = 1'b0;
      for (int k = 1; k <= n + UVF + CLR + 8; k++) begin
        tick();
        if (k == n) begin
          uvb = 1'b0;
          uva = 1'b1;
        end
        chk(flt_pull_low, trip && (k >= 3 + UVF) && (k < rel), "R3 R5 uv sweep flt");
        chk(gate_out, !(trip && (k >= 3 + UVF) && (k < rel)), "R1 uv sweep gate");
      end
      idle(3);
    end

    // R4 hysteresis: between thresholds the fault persists
    uvb = 1'b1;
    uva = 1'b0;
    idle(UVF + 3);
    uvb = 1'b0;
    for (int k = 1; k <= 3 * CLR; k++) begin
      tick();
      chk(flt_pull_low, 1'b1, "R4 hold between thresholds");
    end
    uva = 1'b1;
    for (int k = 1; k <= 6; k++) begin
      tick();
      chk(flt_pull_low, (k < 4), "R4 release on rise");
    end
    idle(4);

    // R6 reload by a second trip while timer runs
    oc_cmp = 1'b1;
    for (int k = 1; k <= 30; k++) begin
      tick();
      if (k == BLANK + 1) oc_cmp = 1'b0;
      if (k == 8) oc_cmp = 1'b1;
      if (k == 8 + BLANK + 1) oc_cmp = 1'b0;
      chk(flt_pull_low, (k >= 3 + BLANK) && (k < 8 + BLANK + 1 + 3 + CLR), "R6 reload flt");
    end
    idle(4);

    // R8 enable, not latched
    en = 1'b0;
    for (int k = 1; k <= 6; k++) begin
      tick();
      chk(gate_out, (k < 3), "R8 disable gate");
      chk(flt_pull_low, 1'b0, "R8 enable does not latch fault");
    end
    en = 1'b1;
    for (int k = 1; k <= 6; k++) begin
      tick();
      chk(gate_out, (k >= 3), "R8 re-enable gate");
    end

    // R9 pwm follow with 3-cycle latency
    for (int i = 0; i < 64; i++) begin
      hist[i] = ((i * 7 + (i >> 2)) % 3) == 0;
    end
    for (int i = 0; i < 64; i++) begin
      pwm_in = hist[i];
      tick();
      if (i >= 3) chk(gate_out, hist[i - 2], "R9 pwm follow");
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule